// File: doc/BRIEF.md
# Programmable 16-bit Reload/Event Timer

This block is a single-channel 16-bit down counter with a reload value, a control/status word and one pin in, one pin out. Software reaches it over a small byte-wide register bus with four byte addresses. Count ticks come from one of three prescaled versions of the system clock, or from edges on the input pin. When the system clock is the source, the same input pin can instead start the counter on an edge or gate the ticks by its level.

On each underflow the timer raises a sticky flag, which drives the interrupt line when enabled. In periodic operation the counter reloads and keeps running, and the output pin toggles on each underflow. In single-shot operation the counter stops at 0xFFFF, and the output pin marks the interval during which the counter ran. The input pin passes through a two-stage synchroniser before any edge or level is used. The prescaler exponents are parameters fixed at build time.

Top module: `reload_event_timer`

## Requirements
- R1: After reset both control bytes read 0x00, and `tout` and `irq` are 0.
- R2: A write to address 2 or 3 sets the low or high byte of the reload value and leaves the running count unchanged. Reads of addresses 2 and 3 return the low and high byte of the live count. The count changes only on a count tick or a start.
- R3: Writing address 0 with bit 0 (start) set, while bit 1 (enable) of the same write is 1, loads the reload value into the counter and starts it on the next cycle. With the enable bit 0, the start bit does nothing. Bit 0 always reads 0.
- R4: Control byte 1, bits [3:2], selects the tick source: 0, 1 and 2 give one tick every 2^PS0, 2^PS1 and 2^PS2 clocks of a free-running prescaler cleared by reset. 3 selects edges of the input pin.
- R5: A tick taken while the count is 0 is an underflow and sets the flag (address 0, bit 2). With address 0, bit 4 (periodic) set, the counter reloads and keeps running.
- R6: An underflow with bit 4 clear leaves the count at 0xFFFF and stops the counter.
- R7: Writing 0 to bit 2 of address 0 clears the flag, and writing 1 leaves it unchanged. An underflow in the same cycle wins over the clear. `irq` is high exactly while the flag and bit 3 (interrupt enable) are both 1.
- R8: In edge-count mode, mode bit 0 (address 0, bit 7) counts rising edges and mode bit 1 (address 1, bit 0) counts falling edges. Both bits set counts both edges. Edges are detected after two synchroniser flops.
- R9: With an internal source and mode bit 2 (address 1, bit 1) at 0, a nonzero mode bits [1:0] makes the selected pin edge act as a start, just as the start bit does (the enable bit must be 1).
- R10: With an internal source and mode bit 2 set, ticks count only while the synchronised pin equals mode bit 0.
- R11: When address 0, bit 6 (output enable) is 0, `tout` is 0. Otherwise `tout` is the toggle state (periodic) or the running state (single-shot), XOR address 0, bit 5 (invert).
- R12: Writing the enable bit as 0 stops the counter at once and holds the count.
- R13: Bits [7:4] of address 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Byte address: 0/1 control, 2/3 reload (write) or count (read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tin | input | 1 | Event, trigger or gate pin |
| tout | output | 1 | Timer output pin |
| irq | output | 1 | Underflow interrupt request |

## Verification
On every cycle the assertions check several rules. A single-shot underflow lands on 0xFFFF with the counter stopped, and every underflow sets the flag. A start loads the reload value, and the count holds when there is neither a tick nor a start. A cleared enable bit means the counter is idle, and a disabled output stays low. The scenarios cover the rest, which depends on exact tick timing over many cycles: the prescaler phase for each divider, the edge polarity after synchronisation, trigger and gate behaviour, and the write-to-clear rule for the flag. In these scenarios a behavioural model in the bench is compared on each clock against `bus_rdata`, `tout` and `irq`.

// File: rtl/reload_event_timer.sv
module reload_event_timer #(
  parameter int PS0 = 1,
  parameter int PS1 = 3,
  parameter int PS2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tin,
  output logic       tout,
  output logic       irq
);
  localparam int PW = PS2;

  logic [PW-1:0] pre;
  logic [15:0]   cnt, rld;
  logic [2:0]    tsy, mode;
  logic [1:0]    csel;
  logic run, tgl, uf, inte, reld, outl, oute, cnte;

  logic wr_c0, wr_c1, wr_r0, wr_r1;
  logic rise, fall, edge_hit, ext, itick, gate_ok, adv, trig_mode, cnte_n, start, wrap;

  assign wr_c0 = bus_sel & bus_wr & (bus_addr == 2'd0);
  assign wr_c1 = bus_sel & bus_wr & (bus_addr == 2'd1);
  assign wr_r0 = bus_sel & bus_wr & (bus_addr == 2'd2);
  assign wr_r1 = bus_sel & bus_wr & (bus_addr == 2'd3);

  assign rise     = tsy[1] & ~tsy[2];
  assign fall     = ~tsy[1] & tsy[2];
  assign edge_hit = (mode[0] & rise) | (mode[1] & fall);
  assign ext      = (csel == 2'd3);

  always_comb begin
    case (csel)
      2'd0:    itick = &pre[PS0-1:0];
      2'd1:    itick = &pre[PS1-1:0];
      default: itick = &pre[PS2-1:0];
    endcase
  end

  assign gate_ok   = ~mode[2] | (tsy[1] == mode[0]);
  assign adv       = run & (ext ? edge_hit : (itick & gate_ok));
  assign trig_mode = ~ext & ~mode[2] & (mode[1:0] != 2'b00);
  assign cnte_n    = wr_c0 ? bus_wdata[1] : cnte;
  assign start     = cnte_n & ((wr_c0 & bus_wdata[0]) | (trig_mode & edge_hit));
  assign wrap      = adv & cnte_n & ~start & (cnt == 16'h0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      tsy  <= '0;
      cnt  <= '0;
      rld  <= '0;
      mode <= '0;
      csel <= '0;
      {run, tgl, uf, inte, reld, outl, oute, cnte} <= '0;
    end else begin
      pre <= pre + 1'b1;
      tsy <= {tsy[1:0], tin};
      if (wr_c0) {mode[0], oute, outl, reld, inte, cnte} <= {bus_wdata[7:3], bus_wdata[1]};
      if (wr_c1) {csel, mode[2:1]} <= bus_wdata[3:0];
      if (wr_r0) rld[7:0]  <= bus_wdata;
      if (wr_r1) rld[15:8] <= bus_wdata;
      if (wrap) uf <= 1'b1;
      else if (wr_c0 && !bus_wdata[2]) uf <= 1'b0;
      if (start) begin
        cnt <= rld;
        run <= 1'b1;
        tgl <= 1'b0;
      end else if (!cnte_n) begin
        run <= 1'b0;
      end else if (adv) begin
        if (cnt == 16'h0000) begin
          if (reld) begin
            cnt <= rld;
            tgl <= ~tgl;
          end else begin
            cnt <= 16'hFFFF;
            run <= 1'b0;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign tout = oute & ((reld ? tgl : run) ^ outl);
  assign irq  = uf & inte;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {mode[0], oute, outl, reld, inte, uf, cnte, 1'b0};
      2'd1:    bus_rdata = {4'h0, csel, mode[2:1]};
      2'd2:    bus_rdata = cnt[7:0];
      default: bus_rdata = cnt[15:8];
    endcase
  end

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !reld) |=> (!run && cnt == 16'hFFFF));
  // R5
  uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> uf);
  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run && cnt == $past(rld)));
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv || start) |=> $stable(cnt));
  // R12
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnte |-> !run);
  // R11
  tout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oute |-> !tout);
endmodule

// File: tb/reload_event_timer_tb.sv
module reload_event_timer_tb;
  localparam int PS0 = 1, PS1 = 3, PS2 = 5;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, tin = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tout, irq;

  reload_event_timer #(.PS0(PS0), .PS1(PS1), .PS2(PS2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tin(tin), .tout(tout), .irq(irq));

  always #10 clk = ~clk;

  int    total = 0, fails = 0;
  bit    done = 0;
  string phase = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_rld, m_pre, m_csel, m_mode, m_ps, q[3];
  bit m_run, m_tgl, m_uf, m_inte, m_reld, m_outl, m_oute, m_en;
  bit w0, w1, w2, w3, tk, ev, go, trg_ok, en_n, st;

  function automatic int model_rd(input int a);
    case (a)
      0: return {m_mode[0], m_oute, m_outl, m_reld, m_inte, m_uf, m_en, 1'b0};
      1: return (m_csel << 2) | (m_mode >> 1);
      2: return m_cnt & 255;
      default: return (m_cnt >> 8) & 255;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_pre = 0; m_csel = 0; m_mode = 0;
      q[0] = 0; q[1] = 0; q[2] = 0;
      {m_run, m_tgl, m_uf, m_inte, m_reld, m_outl, m_oute, m_en} = '0;
    end else begin
      w0 = bus_sel && bus_wr && bus_addr == 0;
      w1 = bus_sel && bus_wr && bus_addr == 1;
      w2 = bus_sel && bus_wr && bus_addr == 2;
      w3 = bus_sel && bus_wr && bus_addr == 3;
      m_ps = (m_csel == 0) ? PS0 : (m_csel == 1) ? PS1 : PS2;
      tk = (m_pre % (1 << m_ps)) == ((1 << m_ps) - 1);
      ev = ((m_mode & 1) != 0 && q[1] == 1 && q[2] == 0) ||
           ((m_mode & 2) != 0 && q[1] == 0 && q[2] == 1);
      if (m_csel == 3) go = m_run && ev;
      else if ((m_mode & 4) != 0) go = m_run && tk && (q[1] == (m_mode & 1));
      else go = m_run && tk;
      trg_ok = m_csel != 3 && (m_mode & 4) == 0 && (m_mode & 3) != 0;
      en_n = w0 ? bus_wdata[1] : m_en;
      st = en_n && ((w0 && bus_wdata[0]) || (trg_ok && ev));
      if (go && en_n && !st && m_cnt == 0) m_uf = 1;
      else if (w0 && !bus_wdata[2]) m_uf = 0;
      if (st) begin
        m_cnt = m_rld; m_run = 1; m_tgl = 0;
      end else if (!en_n) m_run = 0;
      else if (go) begin
        if (m_cnt == 0) begin
          if (m_reld) begin m_cnt = m_rld; m_tgl = !m_tgl; end
          else begin m_cnt = 16'hFFFF; m_run = 0; end
        end else m_cnt = m_cnt - 1;
      end
      if (w0) begin
        m_mode = (m_mode & 6) | bus_wdata[7];
        {m_oute, m_outl, m_reld, m_inte, m_en} = {bus_wdata[6:3], bus_wdata[1]};
      end
      if (w1) begin
        m_csel = bus_wdata[3:2];
        m_mode = (m_mode & 1) | (bus_wdata[1:0] << 1);
      end
      if (w2) m_rld = (m_rld & 16'hFF00) | bus_wdata;
      if (w3) m_rld = (m_rld & 16'h00FF) | (bus_wdata << 8);
      q[2] = q[1]; q[1] = q[0]; q[0] = tin;
      m_pre++;
    end
  end

  always @(posedge clk) begin
    #15;
    if (rst_n && !done) begin
      check(bus_rdata == model_rd(bus_addr) &&
            tout == (m_oute && ((m_reld ? m_tgl : m_run) ^ m_outl)) &&
            irq == (m_uf && m_inte),
            phase, {bus_rdata, tout, irq},
            {model_rd(bus_addr), 1'(m_oute && ((m_reld ? m_tgl : m_run) ^ m_outl)), 1'(m_uf && m_inte)});
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = 2'd2;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 2'(a);
    #2 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_cnt(output int c);
    int lo, hi;
    rd(2, lo); rd(3, hi);
    c = (hi << 8) | lo;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tin = 1; idle(4);
      @(negedge clk); tin = 0; idle(4);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int d, c;
    idle(3);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(0, d); check(d == 0, "R1 ctl0", d, 0);
    rd(1, d); check(d == 0, "R1 ctl1", d, 0);
    check(tout == 0 && irq == 0, "R1 pins", {tout, irq}, 0);
    // R13
    phase = "R13";
    wr(1, 8'hFF); rd(1, d); check((d & 8'hF0) == 0, "R13 upper nibble", d, d & 15);
    wr(1, 8'h00);
    // R2 reload write does not touch count
    phase = "R2";
    wr(2, 8'h03); wr(3, 8'h00);
    rd_cnt(c); check(c == 0, "R2 count untouched by reload write", c, 0);
    // R3 start without enable: no effect
    phase = "R3";
    wr(0, 8'h49); idle(4);
    rd_cnt(c); check(c == 0, "R3 start ignored without enable", c, 0);
    check(tout == 0, "R3 not running", tout, 0);
    // R6 one-shot, div 2, reload 3
    phase = "R6";
    wr(0, 8'h4B);
    rd(0, d); check((d & 1) == 0, "R3 start bit reads 0", d & 1, 0);
    check(tout == 1, "R11 one-shot level while running", tout, 1);
    idle(20);
    rd_cnt(c); check(c == 16'hFFFF, "R6 stop at FFFF", c, 16'hFFFF);
    check(tout == 0, "R11 one-shot level after stop", tout, 0);
    rd(0, d); check((d & 4) != 0, "R5 flag set", d & 4, 4);
    check(irq == 1, "R7 irq with flag and enable", irq, 1);
    // R7 write-0-to-clear
    phase = "R7";
    wr(0, 8'h4E); rd(0, d); check((d & 4) != 0, "R7 write 1 keeps flag", d & 4, 4);
    wr(0, 8'h4A); rd(0, d); check((d & 4) == 0, "R7 write 0 clears flag", d & 4, 0);
    check(irq == 0, "R7 irq low", irq, 0);
    // R5 periodic, div 8, reload 2; R11 toggle, invert, disable
    phase = "R5";
    wr(2, 8'h02); wr(1, 8'h04); wr(0, 8'h53);
    idle(120);
    rd(0, d); check((d & 4) != 0, "R5 flag after periodic underflow", d & 4, 4);
    rd_cnt(c); check(c <= 2, "R5 reload keeps count in range", c, 2);
    phase = "R11";
    wr(0, 8'h72); idle(60);
    wr(0, 8'h32); idle(3);
    check(tout == 0, "R11 output disabled", tout, 0);
    // R12 stop by clearing enable
    phase = "R12";
    wr(0, 8'h10); rd_cnt(c); idle(40); rd_cnt(d);
    check(c == d, "R12 count held after disable", d, c);
    // R4 slowest divider, one-shot reload 1
    phase = "R4";
    wr(2, 8'h01); wr(1, 8'h08); wr(0, 8'h43); idle(10);
    rd_cnt(c); check(c != 16'hFFFF, "R4 slow divider still counting", c, 1);
    idle(100);
    rd_cnt(c); check(c == 16'hFFFF, "R4 slow divider finished", c, 16'hFFFF);
    // R8 event count: rising edges, reload 4
    phase = "R8";
    wr(0, 8'h00); wr(2, 8'h04); wr(1, 8'h0C); wr(0, 8'hC3);
    pulse(4);
    rd_cnt(c); check(c == 0, "R8 four rising edges", c, 0);
    pulse(1); idle(4);
    rd_cnt(c); check(c == 16'hFFFF, "R8 fifth edge underflows", c, 16'hFFFF);
    wr(2, 8'h03); wr(1, 8'h0D); wr(0, 8'hC3);
    pulse(1); idle(4);
    rd_cnt(c); check(c == 1, "R8 both edges count", c, 1);
    pulse(1); idle(4);
    rd_cnt(c); check(c == 16'hFFFF, "R8 both edges underflow", c, 16'hFFFF);
    // R9 falling-edge trigger, periodic, reload 5
    phase = "R9";
    wr(0, 8'h00); wr(2, 8'h05); wr(1, 8'h01); wr(0, 8'h52);
    @(negedge clk); tin = 1; idle(10);
    rd_cnt(c); check(c == 16'hFFFF, "R9 rising edge does not start", c, 16'hFFFF);
    @(negedge clk); tin = 0; idle(10);
    rd_cnt(c); check(c <= 5, "R9 falling edge starts", c, 5);
    // R10 gate, active high, reload 7
    phase = "R10";
    wr(0, 8'h00); wr(2, 8'h07); wr(1, 8'h02); wr(0, 8'hD3);
    idle(20);
    rd_cnt(c); check(c == 7, "R10 gate closed holds count", c, 7);
    @(negedge clk); tin = 1; idle(8);
    rd_cnt(c); check(c < 7, "R10 gate open counts", c, 6);
    @(negedge clk); tin = 0; idle(3);
    rd_cnt(c); idle(20); rd_cnt(d);
    check(c == d, "R10 gate closed again holds", d, c);
    idle(2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule